// File: doc/BRIEF.md
# E3 Receive Performance Monitor with Far-End Block Error Loop-Back

This block sits behind an E3 receive framer. For each received frame it gets one boundary strobe together with the frame's results: an 8-bit mask of the bit positions that failed the parity (BIP-8) check, the far-end block error (FEBE) bit from the maintenance byte, and four other alarm flags. It keeps two 16-bit performance counters and an 8-bit interrupt status register, all of which clear when read. It also asks the local transmit framer to set FEBE in the next outgoing frame whenever the received parity check failed.

A microprocessor reaches the block through an 8-bit register port. Read data is registered and appears one cycle after the read strobe. An interrupt-enable register masks the status bits, and the enabled bits that are set drive a single interrupt line.

Top module: `e3_pmon`

## Requirements
- R1: On every frame strobe the parity counter grows by the number of set bits in `em_mismatch` (0 to 8). The counter's upper byte reads at address 0x54 and its lower byte at 0x55.
- R2: On every frame strobe with `rx_febe` = 1 the FEBE counter grows by exactly one. Its upper byte reads at 0x56 and its lower byte at 0x57.
- R3: Both counters are zero after reset. Reading an upper byte returns bits 15:8, copies bits 7:0 into a shadow byte and clears the counter. Reading the matching lower byte returns the shadow byte and then clears the shadow byte.
- R4: `tx_febe_req` updates at each frame strobe. It is 1 from the cycle after the strobe of a frame with a nonzero `em_mismatch` until the next strobe, and 0 otherwise. It is 0 after reset.
- R5: The status register at 0x15 uses these bits, each set by a frame strobe: bit 6 `rx_trace_chg`, bit 4 `rx_febe`, bit 3 `rx_ferf`, bit 2 nonzero `em_mismatch`, bit 1 `rx_fbyte_err`, bit 0 `rx_pld_mis`. Reading the register returns its contents and clears them.
- R6: Status bits 7 and 5 always read as 0.
- R7: The parity counter saturates at 0xFFFF and never wraps.
- R8: The interrupt-enable register at 0x14 is read/write and is 0 after reset. `irq` is 1 exactly when some status bit and its enable bit are both 1.
- R9: When an increment and a clearing read of the same counter or of the status register fall in the same cycle, the register keeps the new increment instead of zero.
- R10: Frame inputs are ignored while `frm_strobe` is 0. Reads from unassigned addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frm_strobe | input | 1 | One-cycle pulse carrying one received frame's results |
| em_mismatch | input | 8 | Failing parity bit positions of the frame |
| rx_febe | input | 1 | Received FEBE bit |
| rx_trace_chg | input | 1 | Trail-trace change seen |
| rx_ferf | input | 1 | Far-end receive failure bit |
| rx_fbyte_err | input | 1 | Framing byte error |
| rx_pld_mis | input | 1 | Payload type mismatch |
| reg_addr | input | 8 | Register address |
| reg_rd | input | 1 | Read strobe |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid the cycle after `reg_rd` |
| irq | output | 1 | Interrupt request |
| tx_febe_req | output | 1 | Request to set FEBE in the next transmitted frame |

## Verification
The bench sweeps all 256 parity mismatch patterns with the FEBE bit toggling, and checks the sums against population counts it computes itself. A design that added 1 per errored frame, or that read the low byte live instead of from the snapshot, would return wrong sums. It drives the parity counter past 0xFFFF, which catches a counter that wraps to a small value. It lines up a frame strobe with each clearing read, so a design that lets the clear win would drop an event. It also steps every enable bit against every status source and checks `tx_febe_req` after each frame, which catches a request that is held too long or that is tied to the wrong frame.

// File: rtl/e3_pmon_pkg.sv
// Shared constants and helpers for the E3 performance monitor.
// Assumes an 8-bit register address space and 16-bit counters.
package e3_pmon_pkg;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 8;
    localparam int CNT_W  = 16;
    localparam int MASK_W = 8;
    localparam int POP_W  = $clog2(MASK_W + 1);

    localparam logic [ADDR_W-1:0] A_IRQ_EN  = 8'h14;
    localparam logic [ADDR_W-1:0] A_STATUS  = 8'h15;
    localparam logic [ADDR_W-1:0] A_PAR_HI  = 8'h54;
    localparam logic [ADDR_W-1:0] A_PAR_LO  = 8'h55;
    localparam logic [ADDR_W-1:0] A_FEBE_HI = 8'h56;
    localparam logic [ADDR_W-1:0] A_FEBE_LO = 8'h57;

    // Status bit positions
    localparam int ST_TRACE = 6;
    localparam int ST_FEBE  = 4;
    localparam int ST_FERF  = 3;
    localparam int ST_BIP   = 2;
    localparam int ST_FBYTE = 1;
    localparam int ST_PLD   = 0;

    // Number of ones in a mismatch mask
    function automatic logic [POP_W-1:0] pop_count(input logic [MASK_W-1:0] m);
        logic [POP_W-1:0] n;
        n = '0;
        for (int i = 0; i < MASK_W; i++) begin
            n = n + POP_W'(m[i]);
        end
        return n;
    endfunction
endpackage

// File: rtl/e3_pmon_cnt.sv
// Saturating event counter that clears on read, with a coherent low-byte snapshot.
// Assumes that the upper-byte read comes first: it copies the low byte into a
// shadow and clears the counter. A lower-byte read returns the shadow and clears
// it. An increment in the same cycle as a clear is kept.
module e3_pmon_cnt #(
    parameter int CNT_W = 16,
    parameter int INC_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_en,
    input  logic [INC_W-1:0] inc_val,
    input  logic             rd_hi,
    input  logic             rd_lo,
    output logic [CNT_W-1:0] count,
    output logic [7:0]       shadow
);
    localparam int LO_W = 8;
    localparam logic [CNT_W-1:0] MAXV = '1;

    logic [CNT_W-1:0] base;
    logic [CNT_W:0]   sum;
    logic [CNT_W-1:0] nxt;

    // Next count: clear first if read, then add and saturate
    always_comb begin
        base = rd_hi ? '0 : count;
        sum  = {1'b0, base} + (CNT_W+1)'(inc_val);
        if (!inc_en)
            nxt = base;
        else if (sum[CNT_W])
            nxt = MAXV;
        else
            nxt = sum[CNT_W-1:0];
    end

    // Counter register
    always_ff @(posedge clk) begin
        if (!rst_n) count <= '0;
        else        count <= nxt;
    end

    // Shadow byte: loaded on upper-byte read, cleared on lower-byte read
    always_ff @(posedge clk) begin
        if (!rst_n)     shadow <= '0;
        else if (rd_hi) shadow <= count[LO_W-1:0];
        else if (rd_lo) shadow <= '0;
    end
endmodule

// File: rtl/e3_pmon_stat.sv
// Interrupt status register that clears on read, with an enable mask and interrupt output.
// Assumes that event bits arrive already qualified by the frame strobe. A set
// that coincides with a clearing read is kept.
module e3_pmon_stat #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_bits,
    input  logic         rd_clr,
    input  logic         en_wr,
    input  logic [W-1:0] en_wdata,
    output logic [W-1:0] status,
    output logic [W-1:0] enable,
    output logic         irq
);
    // Status: OR in new events, drop old contents on read
    always_ff @(posedge clk) begin
        if (!rst_n)      status <= '0;
        else if (rd_clr) status <= set_bits;
        else             status <= status | set_bits;
    end

    // Enable mask register
    always_ff @(posedge clk) begin
        if (!rst_n)     enable <= '0;
        else if (en_wr) enable <= en_wdata;
    end

    // Interrupt: any enabled pending bit
    assign irq = |(status & enable);
endmodule

// File: rtl/e3_pmon.sv
// E3 receive performance monitor top level.
// Takes one strobe per received frame with its parity mismatch mask and alarm
// flags. Keeps the parity and FEBE counters and the interrupt status, and asks
// the transmit side for FEBE in the frame after a parity failure.
// Assumes frm_strobe lasts one cycle per frame. Read data is registered.
module e3_pmon
    import e3_pmon_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frm_strobe,
    input  logic [MASK_W-1:0] em_mismatch,
    input  logic              rx_febe,
    input  logic              rx_trace_chg,
    input  logic              rx_ferf,
    input  logic              rx_fbyte_err,
    input  logic              rx_pld_mis,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq,
    output logic              tx_febe_req
);
    logic [POP_W-1:0]  par_inc;
    logic              par_err;
    logic [CNT_W-1:0]  par_cnt, febe_cnt;
    logic [7:0]        par_shd, febe_shd;
    logic [DATA_W-1:0] st_set, status, irq_en, rd_mux;
    logic rd_par_hi, rd_par_lo, rd_febe_hi, rd_febe_lo, rd_stat;

    // Frame result decode
    always_comb begin
        par_inc = pop_count(em_mismatch);
        par_err = |em_mismatch;
    end

    // Read strobe decode per register
    always_comb begin
        rd_par_hi  = reg_rd && (reg_addr == A_PAR_HI);
        rd_par_lo  = reg_rd && (reg_addr == A_PAR_LO);
        rd_febe_hi = reg_rd && (reg_addr == A_FEBE_HI);
        rd_febe_lo = reg_rd && (reg_addr == A_FEBE_LO);
        rd_stat    = reg_rd && (reg_addr == A_STATUS);
    end

    // Status events of this frame
    always_comb begin
        st_set = '0;
        if (frm_strobe) begin
            st_set[ST_TRACE] = rx_trace_chg;
            st_set[ST_FEBE]  = rx_febe;
            st_set[ST_FERF]  = rx_ferf;
            st_set[ST_BIP]   = par_err;
            st_set[ST_FBYTE] = rx_fbyte_err;
            st_set[ST_PLD]   = rx_pld_mis;
        end
    end

    e3_pmon_cnt #(.CNT_W(CNT_W), .INC_W(POP_W)) u_par_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc_en  (frm_strobe),
        .inc_val (par_inc),
        .rd_hi   (rd_par_hi),
        .rd_lo   (rd_par_lo),
        .count   (par_cnt),
        .shadow  (par_shd)
    );

    e3_pmon_cnt #(.CNT_W(CNT_W), .INC_W(1)) u_febe_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc_en  (frm_strobe && rx_febe),
        .inc_val (1'b1),
        .rd_hi   (rd_febe_hi),
        .rd_lo   (rd_febe_lo),
        .count   (febe_cnt),
        .shadow  (febe_shd)
    );

    e3_pmon_stat #(.W(DATA_W)) u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_bits (st_set),
        .rd_clr   (rd_stat),
        .en_wr    (reg_wr && (reg_addr == A_IRQ_EN)),
        .en_wdata (reg_wdata),
        .status   (status),
        .enable   (irq_en),
        .irq      (irq)
    );

    // Loop-back request: valid for the whole frame after a failed check
    always_ff @(posedge clk) begin
        if (!rst_n)          tx_febe_req <= 1'b0;
        else if (frm_strobe) tx_febe_req <= par_err;
    end

    // Read data selection
    always_comb begin
        case (reg_addr)
            A_IRQ_EN:  rd_mux = irq_en;
            A_STATUS:  rd_mux = status;
            A_PAR_HI:  rd_mux = par_cnt[CNT_W-1:8];
            A_PAR_LO:  rd_mux = par_shd;
            A_FEBE_HI: rd_mux = febe_cnt[CNT_W-1:8];
            A_FEBE_LO: rd_mux = febe_shd;
            default:   rd_mux = '0;
        endcase
    end

    // Registered read data
    always_ff @(posedge clk) begin
        if (!rst_n)      reg_rdata <= '0;
        else if (reg_rd) reg_rdata <= rd_mux;
    end
endmodule

// File: rtl/e3_pmon_chk.sv
// Assertion checker for e3_pmon, attached with bind.
// Assumes the top module's internal counter buses par_cnt and febe_cnt.
module e3_pmon_chk
    import e3_pmon_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              frm_strobe,
    input logic [MASK_W-1:0] em_mismatch,
    input logic              rx_febe,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_rd,
    input logic [DATA_W-1:0] reg_rdata,
    input logic              irq,
    input logic              tx_febe_req,
    input logic [CNT_W-1:0]  par_cnt,
    input logic [CNT_W-1:0]  febe_cnt
);
    AST_TXREQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        frm_strobe |=> (tx_febe_req == ($past(em_mismatch) != '0))); // R4
    AST_TXREQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !frm_strobe |=> $stable(tx_febe_req)); // R4
    AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == A_STATUS) |=> (reg_rdata[7] == 1'b0 && reg_rdata[5] == 1'b0)); // R6
    AST_PAR_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == A_PAR_HI && !frm_strobe) |=> (par_cnt == '0)); // R3
    AST_FEBE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == A_FEBE_HI && !frm_strobe) |=> (febe_cnt == '0)); // R3
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_rd && reg_addr == A_PAR_HI) |=> (par_cnt >= $past(par_cnt))); // R7
    AST_FEBE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_strobe && rx_febe && !(reg_rd && reg_addr == A_FEBE_HI) && febe_cnt != '1)
        |=> (febe_cnt == $past(febe_cnt) + 1'b1)); // R2
    AST_IRQ_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == A_STATUS && !frm_strobe) |=> !irq); // R8
    AST_IDLE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (!frm_strobe && !reg_rd) |=> ($stable(par_cnt) && $stable(febe_cnt))); // R10
endmodule

bind e3_pmon e3_pmon_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .frm_strobe  (frm_strobe),
    .em_mismatch (em_mismatch),
    .rx_febe     (rx_febe),
    .reg_addr    (reg_addr),
    .reg_rd      (reg_rd),
    .reg_rdata   (reg_rdata),
    .irq         (irq),
    .tx_febe_req (tx_febe_req),
    .par_cnt     (par_cnt),
    .febe_cnt    (febe_cnt)
);

// File: tb/e3_pmon_tb.sv
// Self-checking bench for e3_pmon: pattern sweeps with expected sums computed here.
module e3_pmon_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frm_strobe = 1'b0;
    logic [7:0] em_mismatch = '0;
    logic rx_febe = 1'b0, rx_trace_chg = 1'b0, rx_ferf = 1'b0;
    logic rx_fbyte_err = 1'b0, rx_pld_mis = 1'b0;
    logic [7:0] reg_addr = '0;
    logic reg_rd = 1'b0, reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic irq, tx_febe_req;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    e3_pmon u_dut (
        .clk(clk), .rst_n(rst_n), .frm_strobe(frm_strobe), .em_mismatch(em_mismatch),
        .rx_febe(rx_febe), .rx_trace_chg(rx_trace_chg), .rx_ferf(rx_ferf),
        .rx_fbyte_err(rx_fbyte_err), .rx_pld_mis(rx_pld_mis), .reg_addr(reg_addr),
        .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq), .tx_febe_req(tx_febe_req)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Register read: strobe for one cycle, data sampled at the next falling edge
    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    // One frame: strobe for one cycle with its results
    task automatic frame(input logic [7:0] mm, input logic fb, input logic [3:0] al);
        @(negedge clk);
        frm_strobe = 1'b1; em_mismatch = mm; rx_febe = fb;
        {rx_trace_chg, rx_ferf, rx_fbyte_err, rx_pld_mis} = al;
        @(negedge clk);
        frm_strobe = 1'b0; em_mismatch = '0; rx_febe = 1'b0;
        {rx_trace_chg, rx_ferf, rx_fbyte_err, rx_pld_mis} = 4'b0;
    endtask

    // Read a 16-bit counter: upper byte first, then lower
    task automatic rd16(input logic [7:0] hi_a, output int v);
        logic [7:0] h, l;
        rd(hi_a, h);
        rd(hi_a + 8'd1, l);
        v = {h, l};
    endtask

    initial begin
        int tick = 0;
        while (!done && tick < WATCHDOG) begin
            @(posedge clk);
            tick++;
        end
        if (!done) begin
            n_checks++; n_errors++;
            $display("FAIL watchdog actual=%0d expected=<%0d", tick, WATCHDOG);
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        int v, exp_par, exp_febe;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // Reset state, R3 R4 R8
        check("R4 reset tx_febe_req", int'(tx_febe_req), 0);
        check("R8 reset irq", int'(irq), 0);
        rd16(8'h54, v); check("R3 reset parity count", v, 0);
        rd16(8'h56, v); check("R3 reset febe count", v, 0);
        rd(8'h14, d); check("R8 reset enable", int'(d), 0);

        // Sweep all mismatch patterns, read every 16 frames, R1 R2 R4
        exp_par = 0; exp_febe = 0;
        for (int m = 0; m < 256; m++) begin
            frame(8'(m), 1'(m % 3 == 0), 4'b0);
            exp_par += $countones(8'(m));
            exp_febe += (m % 3 == 0) ? 1 : 0;
            check("R4 tx request after frame", int'(tx_febe_req), (m != 0) ? 1 : 0);
            if (m % 16 == 15) begin
                rd16(8'h54, v); check("R1 parity sum", v, exp_par);
                rd16(8'h56, v); check("R2 febe sum", v, exp_febe);
                exp_par = 0; exp_febe = 0;
            end
        end
        // Request cleared by a clean frame, R4
        frame(8'h01, 1'b0, 4'b0);
        check("R4 request set", int'(tx_febe_req), 1);
        repeat (3) @(negedge clk);
        check("R4 request held between strobes", int'(tx_febe_req), 1);
        frame(8'h00, 1'b0, 4'b0);
        check("R4 request dropped", int'(tx_febe_req), 0);
        rd16(8'h54, v);
        rd(8'h15, d);

        // Lower byte returns the snapshot, not the live value, R3
        frame(8'h0F, 1'b0, 4'b0);
        rd(8'h54, d); check("R3 upper byte", int'(d), 0);
        frame(8'hFF, 1'b0, 4'b0);
        rd(8'h55, d); check("R3 lower byte snapshot", int'(d), 4);
        rd(8'h55, d); check("R3 shadow cleared", int'(d), 0);
        rd16(8'h54, v); check("R3 count after clear", v, 8);

        // Saturation, R7
        for (int i = 0; i < 8200; i++) frame(8'hFF, 1'b0, 4'b0);
        rd16(8'h54, v); check("R7 parity saturates", v, 16'hFFFF);
        rd16(8'h54, v); check("R7 cleared after saturation", v, 0);
        rd(8'h15, d);

        // Status bits per source and unused bits, R5 R6 R8
        wr(8'h14, 8'hFF);
        rd(8'h14, d); check("R8 enable readback", int'(d), 8'hFF);
        for (int s = 0; s < 6; s++) begin
            logic [7:0] expv;
            logic [3:0] al;
            logic [7:0] mm;
            logic fb;
            al = '0; mm = '0; fb = 1'b0;
            case (s)
                0: begin al = 4'b1000; expv = 8'h40; end
                1: begin fb = 1'b1;    expv = 8'h10; end
                2: begin al = 4'b0100; expv = 8'h08; end
                3: begin mm = 8'h80;   expv = 8'h04; end
                4: begin al = 4'b0010; expv = 8'h02; end
                default: begin al = 4'b0001; expv = 8'h01; end
            endcase
            frame(mm, fb, al);
            check("R8 irq on enabled source", int'(irq), 1);
            rd(8'h15, d); check("R5 status bit", int'(d), int'(expv));
            check("R6 bits 7 and 5 zero", int'(d & 8'hA0), 0);
            check("R8 irq cleared by read", int'(irq), 0);
            rd(8'h15, d); check("R5 status cleared", int'(d), 0);
        end
        // Enable masking, R8
        for (int e = 0; e < 8; e++) begin
            wr(8'h14, 8'(1 << e));
            frame(8'h01, 1'b1, 4'b1111);
            check("R8 irq under mask", int'(irq), (e == 5 || e == 7) ? 0 : 1);
            rd(8'h15, d); check("R6 status with all sources", int'(d), 8'h5F);
        end
        rd16(8'h54, v);
        rd16(8'h56, v);

        // Same-cycle increment and clearing read, R9
        frame(8'h03, 1'b1, 4'b0);
        @(negedge clk);
        reg_addr = 8'h54; reg_rd = 1'b1;
        frm_strobe = 1'b1; em_mismatch = 8'h07; rx_febe = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0; frm_strobe = 1'b0; em_mismatch = '0; rx_febe = 1'b0;
        check("R9 upper byte on collision", int'(reg_rdata), 0);
        rd(8'h55, d); check("R9 snapshot on collision", int'(d), 2);
        rd16(8'h54, v); check("R9 increment kept", v, 3);
        @(negedge clk);
        reg_addr = 8'h15; reg_rd = 1'b1;
        frm_strobe = 1'b1; rx_febe = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0; frm_strobe = 1'b0; rx_febe = 1'b0;
        check("R9 status read returns old", int'(reg_rdata), 8'h14);
        rd(8'h15, d); check("R9 status set kept", int'(d), 8'h10);
        rd16(8'h56, v); check("R9 febe count", v, 3);

        // Inputs without strobe ignored, unassigned address, R10
        @(negedge clk);
        em_mismatch = 8'hFF; rx_febe = 1'b1; rx_ferf = 1'b1;
        repeat (4) @(negedge clk);
        em_mismatch = '0; rx_febe = 1'b0; rx_ferf = 1'b0;
        rd16(8'h54, v); check("R10 parity unchanged", v, 0);
        rd16(8'h56, v); check("R10 febe unchanged", v, 0);
        rd(8'h15, d); check("R10 status unchanged", int'(d), 0);
        check("R10 tx request unchanged", int'(tx_febe_req), 0);
        rd(8'h33, d); check("R10 unassigned reads zero", int'(d), 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule